// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block decides where a 32-bit core fetches next. From the current program counter, the fetched instruction word and the two register operand values it chooses among straight-line flow (PC+4), a conditional branch on equality or inequality, an absolute jump that splices an instruction index into the upper bits of PC+4, a jump-and-link, and a register-indirect jump. It also flags when a flow change is taken. For jump-and-link it produces a write of the return address to register 31.

The return address is PC+8, so the instruction in the single delay slot is skipped on return. The block does not fetch, flush or execute that slot. It holds the program counter in a register with a synchronous reset and a load enable, so the surrounding pipeline can stall it. Register-indirect jumps to an address that is not word-aligned raise an address-error flag for the exception logic.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes the reset address 0x0040_0000, whatever `adv_en` is.
- R2: When bits [31:26] of the instruction hold a value other than 0x00, 0x02, 0x03, 0x04 or 0x05, `next_pc` is `pc_q`+4 and `taken` is 0.
- R3: Opcode 0x04 (branch if equal): when `rs_val` equals `rt_val`, `next_pc` is `pc_q`+4 plus the 16-bit immediate in bits [15:0], sign-extended and shifted left by two, and `taken` is 1. Otherwise `next_pc` is `pc_q`+4 and `taken` is 0.
- R4: Opcode 0x05 (branch if not equal) takes the branch, with the R3 target, exactly when `rs_val` differs from `rt_val`. Otherwise it gives `pc_q`+4 with `taken` 0.
- R5: A negative immediate gives a backward branch target below `pc_q`+4.
- R6: Opcode 0x02 (jump): `next_pc` is bits [31:28] of `pc_q`+4, then instruction bits [25:0], then two zero bits. `taken` is 1. The upper nibble comes from `pc_q`+4, not from `pc_q`.
- R7: Opcode 0x03 (jump and link) jumps to the R6 target and sets `link_we` to 1, with `link_addr` 31 and `link_data` equal to `pc_q`+8. For every other instruction `link_we` is 0.
- R8: Opcode 0x00 with bits [5:0] equal to 0x08 (register jump) gives `next_pc` equal to `rs_val` and `taken` 1. Opcode 0x00 with any other value in bits [5:0] is straight-line flow.
- R9: `addr_err` is 1 exactly when a register jump is decoded and bits [1:0] of `rs_val` are not both zero. For all other cases it is 0.
- R10: When `adv_en` is 0 and `rst` is 0, `pc_q` keeps its value across the clock edge.
- R11: When `adv_en` is 1 and `rst` is 0, `pc_q` takes the value `next_pc` had before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Load enable for the PC register |
| instr | input | 32 | Instruction word at `pc_q` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Computed next program counter |
| taken | output | 1 | Flow change taken (branch taken or any jump) |
| link_we | output | 1 | Return-address write enable |
| link_addr | output | 5 | Destination register of the return address |
| link_data | output | 32 | Return address, `pc_q`+8 |
| addr_err | output | 1 | Misaligned register-jump target |

## Verification
Each branch opcode is driven with equal and with unequal operands. This separates the equality test from its inversion and shows that a not-taken branch falls back to PC+4. A backward offset is used as well, to expose a missing sign extension. A jump is issued from 0x0FFF_FFFC, where PC+4 crosses into a new upper nibble, so splicing from PC rather than PC+4 is caught. Register jumps use aligned and misaligned targets, and an opcode-0 instruction with another function code checks that the jump decode looks at bits [5:0]. Stall and reset cycles confirm that the register only moves when enabled.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int FN_W     = 6;
    localparam int IMM_W    = 16;
    localparam int IDX_W    = 26;
    localparam int REG_W    = 5;
    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int NIB_W    = XLEN - IDX_W - 2;
    localparam int INSN_BYTES = 4;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JMP     = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JAL     = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE     = 6'h05;
    localparam logic [FN_W-1:0]  FN_JREG     = 6'h08;
    localparam logic [REG_W-1:0] LINK_REG    = 5'd31;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        flow_e             kind;
        logic [IMM_W-1:0]  imm;
        logic [IDX_W-1:0]  idx;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] skip;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
    } tgt_t;

    function automatic logic [XLEN-1:0] branch_disp(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] splice_target(input logic [XLEN-1:0] base,
                                                      input logic [IDX_W-1:0] idx);
        return {base[XLEN-1 -: NIB_W], idx, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;

    assign opc = instr[XLEN-1 -: OPC_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        dec.imm  = instr[IMM_W-1:0];
        dec.idx  = instr[IDX_W-1:0];
        dec.kind = FLOW_SEQ;
        unique case (opc)
            OPC_BEQ:     dec.kind = FLOW_BEQ;
            OPC_BNE:     dec.kind = FLOW_BNE;
            OPC_JMP:     dec.kind = FLOW_JMP;
            OPC_JAL:     dec.kind = FLOW_JAL;
            OPC_SPECIAL: dec.kind = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:     dec.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  dec_t            dec,
    output tgt_t            tgt
);
    always_comb begin
        tgt.seq    = pc + XLEN'(INSN_BYTES);
        tgt.skip   = pc + XLEN'(2 * INSN_BYTES);
        tgt.branch = tgt.seq + branch_disp(dec.imm);
        tgt.jump   = splice_target(tgt.seq, dec.idx);
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  dec_t            dec,
    input  tgt_t            tgt,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic            link_we,
    output logic            addr_err
);
    logic same;

    assign same = (rs_val == rt_val);

    always_comb begin
        next_pc  = tgt.seq;
        taken    = 1'b0;
        link_we  = 1'b0;
        addr_err = 1'b0;
        unique case (dec.kind)
            FLOW_BEQ: if (same) begin
                next_pc = tgt.branch;
                taken   = 1'b1;
            end
            FLOW_BNE: if (!same) begin
                next_pc = tgt.branch;
                taken   = 1'b1;
            end
            FLOW_JMP: begin
                next_pc = tgt.jump;
                taken   = 1'b1;
            end
            FLOW_JAL: begin
                next_pc = tgt.jump;
                taken   = 1'b1;
                link_we = 1'b1;
            end
            FLOW_JREG: begin
                next_pc  = rs_val;
                taken    = 1'b1;
                addr_err = |rs_val[1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        adv_en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc_q,
    output logic [31:0] next_pc,
    output logic        taken,
    output logic        link_we,
    output logic [4:0]  link_addr,
    output logic [31:0] link_data,
    output logic        addr_err
);
    dec_t dec;
    tgt_t tgt;

    npc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    npc_target u_tgt (
        .pc  (pc_q),
        .dec (dec),
        .tgt (tgt)
    );

    npc_select u_sel (
        .dec      (dec),
        .tgt      (tgt),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .next_pc  (next_pc),
        .taken    (taken),
        .link_we  (link_we),
        .addr_err (addr_err)
    );

    assign link_addr = LINK_REG;
    assign link_data = tgt.skip;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (adv_en)
            pc_q <= next_pc;
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
)(
    input logic        clk,
    input logic        rst,
    input logic        adv_en,
    input logic [31:0] pc_q,
    input logic [31:0] next_pc,
    input logic        taken,
    input logic        link_we,
    input logic [4:0]  link_addr,
    input logic [31:0] link_data,
    input logic        addr_err
);
    a_r1_reset_value: assert property (@(posedge clk)
        $past(rst) |-> pc_q == RESET_PC);

    a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(pc_q));

    a_r11_loads_next: assert property (@(posedge clk) disable iff (rst)
        adv_en |=> pc_q == $past(next_pc));

    a_r2_fallthrough: assert property (@(posedge clk) disable iff (rst)
        !taken |-> next_pc == pc_q + 32'd4);

    a_r7_link_fields: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_addr == 5'd31 && link_data == pc_q + 32'd8 && taken));

    a_r9_err_misaligned: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (taken && next_pc[1:0] != 2'b00 && !link_we));
endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_en    (adv_en),
    .pc_q      (pc_q),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_addr (link_addr),
    .link_data (link_data),
    .addr_err  (addr_err)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
    logic        clk = 1'b0;
    logic        rst, adv_en;
    logic [31:0] instr, rs_val, rt_val;
    logic [31:0] pc_q, next_pc, link_data;
    logic        taken, link_we, addr_err;
    logic [4:0]  link_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc_q(pc_q), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_addr(link_addr),
        .link_data(link_data), .addr_err(addr_err)
    );

    function automatic logic [31:0] ienc(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd1, 5'd2, imm};
    endfunction
    function automatic logic [31:0] jenc(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction
    function automatic logic [31:0] renc(input logic [5:0] fn);
        return {6'h00, 5'd4, 5'd0, 5'd0, 5'd0, fn};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_pc(input logic [31:0] v);
        instr = renc(6'h08); rs_val = v; adv_en = 1'b1;
        tick();
        adv_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; adv_en = 1'b0; instr = 32'h0; rs_val = 0; rt_val = 0;
        tick(); tick();
        chk("R1 reset pc", pc_q, 32'h0040_0000);
        rst = 1'b0;
    endtask

    task automatic t_seq();
        instr = ienc(6'h08, 16'h0010);
        #1;
        chk("R2 next", next_pc, 32'h0040_0004);
        chk("R2 taken", {31'b0, taken}, 32'd0);
        chk("R7 no link", {31'b0, link_we}, 32'd0);
        adv_en = 1'b1;
        tick();
        chk("R11 advance", pc_q, 32'h0040_0004);
        adv_en = 1'b0;
    endtask

    task automatic t_beq();
        set_pc(32'h0000_1000);
        instr = ienc(6'h04, 16'h0003); rs_val = 32'h55; rt_val = 32'h55;
        #1;
        chk("R3 beq taken pc", next_pc, 32'h0000_1010);
        chk("R3 beq taken flag", {31'b0, taken}, 32'd1);
        rt_val = 32'h56;
        #1;
        chk("R3 beq not taken pc", next_pc, 32'h0000_1004);
        chk("R3 beq not taken flag", {31'b0, taken}, 32'd0);
    endtask

    task automatic t_bne();
        instr = ienc(6'h05, 16'h0003); rs_val = 32'h7; rt_val = 32'h8;
        #1;
        chk("R4 bne taken pc", next_pc, 32'h0000_1010);
        chk("R4 bne taken flag", {31'b0, taken}, 32'd1);
        rt_val = 32'h7;
        #1;
        chk("R4 bne not taken pc", next_pc, 32'h0000_1004);
    endtask

    task automatic t_back();
        instr = ienc(6'h04, 16'hFFFE); rs_val = 0; rt_val = 0;
        #1;
        chk("R5 backward", next_pc, 32'h0000_0FFC);
        adv_en = 1'b1;
        tick();
        chk("R5 R11 loaded backward", pc_q, 32'h0000_0FFC);
        adv_en = 1'b0;
    endtask

    task automatic t_jump();
        set_pc(32'h0FFF_FFFC);
        instr = jenc(6'h02, 26'h000_0010);
        #1;
        chk("R6 jump nibble from pc+4", next_pc, 32'h1000_0040);
        chk("R6 taken", {31'b0, taken}, 32'd1);
        chk("R7 j no link", {31'b0, link_we}, 32'd0);
    endtask

    task automatic t_jal();
        set_pc(32'h2000_2000);
        instr = jenc(6'h03, 26'h3FF_FFFF);
        #1;
        chk("R7 jal target", next_pc, 32'h2FFF_FFFC);
        chk("R7 link_we", {31'b0, link_we}, 32'd1);
        chk("R7 link_addr", {27'b0, link_addr}, 32'd31);
        chk("R7 link_data", link_data, 32'h2000_2008);
    endtask

    task automatic t_jr();
        instr = renc(6'h08); rs_val = 32'h1234_5678;
        #1;
        chk("R8 jr target", next_pc, 32'h1234_5678);
        chk("R8 jr taken", {31'b0, taken}, 32'd1);
        chk("R9 aligned no err", {31'b0, addr_err}, 32'd0);
        rs_val = 32'h0000_3001;
        #1;
        chk("R9 misaligned err", {31'b0, addr_err}, 32'd1);
        rs_val = 32'h0000_3002;
        #1;
        chk("R9 misaligned err b1", {31'b0, addr_err}, 32'd1);
        instr = renc(6'h20);
        #1;
        chk("R8 other funct seq", next_pc, 32'h2000_2004);
        chk("R9 no err on non-jr", {31'b0, addr_err}, 32'd0);
    endtask

    task automatic t_stall();
        instr = jenc(6'h02, 26'h000_1234); adv_en = 1'b0;
        tick(); tick();
        chk("R10 stall holds", pc_q, 32'h2000_2000);
        rst = 1'b1; adv_en = 1'b1;
        tick();
        chk("R1 reset beats enable", pc_q, 32'h0040_0000);
        rst = 1'b0; adv_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_seq();
        t_beq();
        t_bne();
        t_back();
        t_jump();
        t_jal();
        t_jr();
        t_stall();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule